// File: doc/BRIEF.md
# Dual-Port Register File With Pointer Pairs

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. The core reads two registers at once through two combinational byte ports. It writes results back either as one byte or as a 16-bit word that spans an even/odd register pair. A third combinational read port returns a whole register pair as one 16-bit word.

The six highest registers also act as three 16-bit indirect address pointers. These pointers drive dedicated outputs at all times. The low byte of each pointer sits in the even register. A separate data-space port lets a load/store unit read and write any register at byte addresses 0x00 to 0x1F. Addresses from 0x20 upward are reported as a miss, so that the memory outside the block can answer them.

All writes commit on the rising clock edge. A read never forwards a write that is in flight. When several write sources target the same register in one cycle, a fixed priority chooses the one that is stored.

Top module: `regfile_ptr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 registers to 0x00. After reset, every read port and every pointer output reads zero.
- R2: `rd_a_data` and `rd_b_data` show the current contents of the registers selected by `rd_a_idx` and `rd_b_idx` without delay. A byte write (`wb_en`) commits at the rising edge, so the new value appears on the read ports only from the next cycle on. It does not appear in the cycle of the write.
- R3: A pair write (`wp_en`) with an even `wp_idx` stores `wp_data[7:0]` into register `wp_idx` and `wp_data[15:8]` into register `wp_idx+1`. Both bytes are stored on the same edge.
- R4: A pair write with an odd `wp_idx` raises `pair_err` in that same cycle and changes no register.
- R5: `pr_data` returns the value {register (`pr_idx` with bit 0 set), register (`pr_idx` with bit 0 cleared)}. Bit 0 of `pr_idx` is therefore ignored.
- R6: `ptr_x` = {r27,r26}, `ptr_y` = {r29,r28} and `ptr_z` = {r31,r30}. These outputs take a written value in the cycle after the write edge.
- R7: For `ds_addr` below 0x20, `ds_hit` is 1 and `ds_rdata` is register `ds_addr`. With `ds_we` high, `ds_wdata` is stored into that register at the edge.
- R8: For `ds_addr` at 0x20 or above, `ds_hit` is 0 and `ds_rdata` is 0x00. A write to such an address changes no register, including the register that matches the address's low five bits.
- R9: When a core write (byte or pair) and a data-space write reach the same register in one cycle, the core value is stored. Data-space writes to other registers in that cycle still take effect.
- R10: When a byte write and a valid pair write overlap on one register, the pair write's byte is stored. The other byte of the pair is stored as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| pr_idx | input | 5 | Pair read index (bit 0 ignored) |
| pr_data | output | 16 | Pair read data, high register in the upper byte |
| wb_en | input | 1 | Byte write enable |
| wb_idx | input | 5 | Byte write register index |
| wb_data | input | 8 | Byte write data |
| wp_en | input | 1 | Pair write enable |
| wp_idx | input | 5 | Pair write base index, must be even |
| wp_data | input | 16 | Pair write data, low byte to the even register |
| pair_err | output | 1 | Pair write with odd index, write suppressed |
| ds_addr | input | DS_AW (16) | Data-space byte address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data, 0 on a miss |
| ds_hit | output | 1 | Address falls inside the register window |
| ptr_x | output | 16 | Pointer X = {r27,r26} |
| ptr_y | output | 16 | Pointer Y = {r29,r28} |
| ptr_z | output | 16 | Pointer Z = {r31,r30} |

## Verification
The core write-back and the load/store unit's data-space write can land on the same register in the same cycle. The bench provokes this with a byte write and a data-space write to one index under different data values. It then reads the register back on the next cycle and expects the core value. The bench also pairs the core write with a data-space write to a different index and checks that both registers change. The same method, applied to a pair write that overlaps a byte write, judges the priority between the two core write paths.

// File: rtl/regfile_ptr.sv
module regfile_ptr #(
  parameter int DS_AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       rd_a_idx,
  output logic [7:0]       rd_a_data,
  input  logic [4:0]       rd_b_idx,
  output logic [7:0]       rd_b_data,
  input  logic [4:0]       pr_idx,
  output logic [15:0]      pr_data,
  input  logic             wb_en,
  input  logic [4:0]       wb_idx,
  input  logic [7:0]       wb_data,
  input  logic             wp_en,
  input  logic [4:0]       wp_idx,
  input  logic [15:0]      wp_data,
  output logic             pair_err,
  input  logic [DS_AW-1:0] ds_addr,
  input  logic             ds_we,
  input  logic [7:0]       ds_wdata,
  output logic [7:0]       ds_rdata,
  output logic             ds_hit,
  output logic [15:0]      ptr_x,
  output logic [15:0]      ptr_y,
  output logic [15:0]      ptr_z
);
  localparam int NREG = 32;
  localparam int IW   = 5;

  logic [7:0]    rf [NREG];
  logic          pair_ok;
  logic [IW-1:0] ds_idx;

  assign pair_ok  = wp_en & ~wp_idx[0];
  assign pair_err = wp_en &  wp_idx[0];
  assign ds_hit   = ds_addr < DS_AW'(NREG);
  assign ds_idx   = ds_addr[IW-1:0];

  assign rd_a_data = rf[rd_a_idx];
  assign rd_b_data = rf[rd_b_idx];
  assign pr_data   = {rf[{pr_idx[IW-1:1], 1'b1}], rf[{pr_idx[IW-1:1], 1'b0}]};
  assign ds_rdata  = ds_hit ? rf[ds_idx] : 8'h00;

  assign ptr_x = {rf[27], rf[26]};
  assign ptr_y = {rf[29], rf[28]};
  assign ptr_z = {rf[31], rf[30]};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [IW-1:0] IDX = IW'(i);
    logic [7:0] q;
    logic       sel_lo, sel_hi, sel_b, sel_ds;

    assign sel_lo = pair_ok && (wp_idx == IDX);
    assign sel_hi = pair_ok && ({wp_idx[IW-1:1], 1'b1} == IDX);
    assign sel_b  = wb_en && (wb_idx == IDX);
    assign sel_ds = ds_we && ds_hit && (ds_idx == IDX);

    always_ff @(posedge clk) begin
      if (rst)         q <= 8'h00;
      else if (sel_lo) q <= wp_data[7:0];
      else if (sel_hi) q <= wp_data[15:8];
      else if (sel_b)  q <= wb_data;
      else if (sel_ds) q <= ds_wdata;
    end

    assign rf[i] = q;
  end
endmodule

// File: rtl/regfile_ptr_chk.sv
module regfile_ptr_chk #(
  parameter int DS_AW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       rd_a_idx,
  input logic [7:0]       rd_a_data,
  input logic             wb_en,
  input logic [4:0]       wb_idx,
  input logic [7:0]       wb_data,
  input logic             wp_en,
  input logic [4:0]       wp_idx,
  input logic [15:0]      wp_data,
  input logic             pair_err,
  input logic [DS_AW-1:0] ds_addr,
  input logic             ds_we,
  input logic [7:0]       ds_rdata,
  input logic             ds_hit,
  input logic [15:0]      ptr_x,
  input logic [15:0]      ptr_y,
  input logic [15:0]      ptr_z
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_x == 16'h0 && ptr_y == 16'h0 && ptr_z == 16'h0));

  p_no_forward_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !wp_en && !ds_we && wb_idx == rd_a_idx) |=>
      (rd_a_idx != $past(rd_a_idx) || rd_a_data == $past(wb_data)));

  p_pair_x_r3: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_idx == 5'd26) |=> ptr_x == $past(wp_data));

  p_pair_y_r6: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_idx == 5'd28) |=> ptr_y == $past(wp_data));

  p_pair_z_r6: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_idx == 5'd30) |=> ptr_z == $past(wp_data));

  p_odd_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_idx[0]) |-> pair_err);

  p_odd_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wp_idx[0] && !wb_en && !ds_we) |=>
      ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

  p_ds_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (ds_addr >= DS_AW'(32)) |-> (!ds_hit && ds_rdata == 8'h00));

  p_core_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !wp_en && wb_idx == 5'd30 && ds_we && ds_addr == DS_AW'(30)) |=>
      ptr_z[7:0] == $past(wb_data));
endmodule

bind regfile_ptr regfile_ptr_chk #(.DS_AW(DS_AW)) chk_i (.*);

// File: tb/regfile_ptr_tb_top.sv
`timescale 1ns/1ps
module regfile_ptr_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, pr_idx, wb_idx, wp_idx;
  logic [7:0]  rd_a_data, rd_b_data, wb_data, ds_wdata, ds_rdata;
  logic [15:0] pr_data, wp_data, ptr_x, ptr_y, ptr_z, ds_addr;
  logic        wb_en, wp_en, pair_err, ds_we, ds_hit;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  regfile_ptr dut_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .pr_idx(pr_idx), .pr_data(pr_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .wp_en(wp_en), .wp_idx(wp_idx), .wp_data(wp_data),
    .pair_err(pair_err),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_hit(ds_hit),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wb_en = 0; wp_en = 0; ds_we = 0;
    wb_idx = 0; wb_data = 0; wp_idx = 0; wp_data = 0;
    ds_addr = 0; ds_wdata = 0;
  endtask

  task automatic commit();
    @(posedge clk); #1 idle(); @(negedge clk);
  endtask

  task automatic rda(input logic [4:0] i, output logic [7:0] v);
    rd_a_idx = i; #0.5 v = rd_a_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      rda(5'(i), v); chk("R1 reg zero after reset", 16'(v), 16'h0);
    end
    rd_b_idx = 5'd31; #0.5 chk("R1 port b zero", 16'(rd_b_data), 16'h0);
    chk("R1 ptr_x", ptr_x, 16'h0);
    chk("R1 ptr_y", ptr_y, 16'h0);
    chk("R1 ptr_z", ptr_z, 16'h0);
  endtask

  task automatic t_byte();
    logic [7:0] v;
    wb_en = 1; wb_idx = 5'd5; wb_data = 8'hA5;
    rda(5'd5, v); chk("R2 no forwarding before edge", 16'(v), 16'h0);
    commit();
    rda(5'd5, v); chk("R2 port a after edge", 16'(v), 16'hA5);
    rd_b_idx = 5'd5; #0.5 chk("R2 port b after edge", 16'(rd_b_data), 16'hA5);
  endtask

  task automatic t_pair();
    logic [7:0] v;
    wp_en = 1; wp_idx = 5'd26; wp_data = 16'h1234;
    commit();
    chk("R6 ptr_x", ptr_x, 16'h1234);
    rda(5'd26, v); chk("R3 low byte in even reg", 16'(v), 16'h34);
    rda(5'd27, v); chk("R3 high byte in odd reg", 16'(v), 16'h12);
    pr_idx = 5'd26; #0.5 chk("R5 pair read even", pr_data, 16'h1234);
    pr_idx = 5'd27; #0.5 chk("R5 pair read odd idx", pr_data, 16'h1234);
    wp_en = 1; wp_idx = 5'd28; wp_data = 16'hC0DE;
    commit();
    wp_en = 1; wp_idx = 5'd30; wp_data = 16'h8001;
    commit();
    chk("R6 ptr_y", ptr_y, 16'hC0DE);
    chk("R6 ptr_z", ptr_z, 16'h8001);
  endtask

  task automatic t_odd();
    logic [7:0] v;
    wp_en = 1; wp_idx = 5'd29; wp_data = 16'hBEEF;
    #0.5 chk("R4 pair_err raised", 16'(pair_err), 16'h1);
    commit();
    chk("R4 pair_err clear when idle", 16'(pair_err), 16'h0);
    chk("R4 ptr_y unchanged", ptr_y, 16'hC0DE);
    rda(5'd30, v); chk("R4 reg30 unchanged", 16'(v), 16'h01);
  endtask

  task automatic t_ds();
    logic [7:0] v;
    ds_we = 1; ds_addr = 16'h0010; ds_wdata = 8'h77;
    commit();
    rda(5'd16, v); chk("R7 ds write seen on core port", 16'(v), 16'h77);
    ds_addr = 16'h0010; #0.5 chk("R7 ds read", 16'(ds_rdata), 16'h77);
    chk("R7 ds hit", 16'(ds_hit), 16'h1);
    ds_addr = 16'h001F; #0.5 chk("R7 ds read top reg", 16'(ds_rdata), 16'h80);
    ds_addr = 16'h0000;
  endtask

  task automatic t_ds_miss();
    logic [7:0] v;
    ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'h55;
    #0.5 chk("R8 miss at 0x20", 16'(ds_hit), 16'h0);
    commit();
    ds_we = 1; ds_addr = 16'h0045; ds_wdata = 8'h66;
    #0.5 chk("R8 rdata zero on miss", 16'(ds_rdata), 16'h0);
    commit();
    rda(5'd0, v); chk("R8 reg0 untouched", 16'(v), 16'h0);
    rda(5'd5, v); chk("R8 reg5 untouched", 16'(v), 16'hA5);
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    wb_en = 1; wb_idx = 5'd3; wb_data = 8'h11;
    ds_we = 1; ds_addr = 16'h0003; ds_wdata = 8'h22;
    commit();
    rda(5'd3, v); chk("R9 core wins same reg", 16'(v), 16'h11);
    wb_en = 1; wb_idx = 5'd4; wb_data = 8'h33;
    ds_we = 1; ds_addr = 16'h0006; ds_wdata = 8'h44;
    commit();
    rda(5'd4, v); chk("R9 core reg written", 16'(v), 16'h33);
    rda(5'd6, v); chk("R9 ds reg written", 16'(v), 16'h44);
  endtask

  task automatic t_pair_vs_byte();
    logic [7:0] v;
    wp_en = 1; wp_idx = 5'd8; wp_data = 16'hABCD;
    wb_en = 1; wb_idx = 5'd9; wb_data = 8'h99;
    commit();
    rda(5'd9, v); chk("R10 pair wins overlap", 16'(v), 16'hAB);
    rda(5'd8, v); chk("R10 other byte of pair", 16'(v), 16'hCD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rd_a_idx = 0; rd_b_idx = 0; pr_idx = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset();
    t_byte();
    t_pair();
    t_odd();
    t_ds();
    t_ds_miss();
    t_conflict();
    t_pair_vs_byte();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule